// File: doc/BRIEF.md
# Toggle-Request Half-Cycle RAM Port

This block is a word-addressed single-port memory placed beside a state-machine data path. The data path asks for an access by flipping a single request bit on a rising clock edge. On that same edge it also presents a word address, a write enable and, for a store, the word to be written. The memory keeps its own copy of that bit. It acts only when the two bits disagree, and it does its work on the falling edge that follows. A load or a store is therefore finished inside the one data-path cycle in which it was issued.

A load result is held in a read-data register, which is updated on the falling edge. On the next rising edge the block moves that word into a one-word destination register, where the data path picks it up. Each memory location is a whole word and is selected by its word index. An address at or beyond the configured depth never changes a stored word, and a load from such an address returns zero.

Top module: `tgl_ram_port`

## Requirements
- R1: After reset, `rd_data_o` and `dest_o` read zero. The internal copy bit is 0, so no access takes place while `req_tgl_i` stays 0.
- R2: An access takes place only on a falling edge at which `req_tgl_i` differs from the internal copy bit. That edge sets the copy equal to `req_tgl_i`. If the toggle is not flipped, nothing is written, whatever the other inputs are.
- R3: A load (`wr_en_i` = 0) copies the word at `addr_i` into `rd_data_o` on the falling edge. The value is visible before the next rising edge.
- R4: On the rising edge that follows a load's falling edge, `dest_o` takes the value of `rd_data_o`. At every other rising edge, `dest_o` holds its value.
- R5: A store (`wr_en_i` = 1) writes `wr_data_i` to the word at `addr_i` on the falling edge. The stored value is seen by any later load.
- R6: Memory holds DEPTH words of DATA_W bits (defaults 48 and 32), selected by word index. Storing to one index leaves every other index unchanged.
- R7: A store to an address at or above DEPTH changes no stored word.
- R8: A load from an address at or above DEPTH returns zero in `rd_data_o`, and then in `dest_o`.
- R9: A load issued in the cycle directly after a store to the same address returns the newly stored word.
- R10: Requests issued on consecutive rising edges, with the toggle flipped every cycle, are each serviced in their own cycle.
- R11: A store, or a cycle with no request, leaves `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The data path uses the rising edge; the memory uses the falling edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| req_tgl_i | input | 1 | Request toggle. Flip it to start one access. |
| addr_i | input | ADDR_W | Word index of the access. |
| wr_en_i | input | 1 | 1 = store, 0 = load. |
| wr_data_i | input | DATA_W | Word to store. |
| rd_data_o | output | DATA_W | Read-data register, updated on the falling edge of a load. |
| dest_o | output | DATA_W | Destination register, loaded on the rising edge after a load. |

## Verification
Distinct word patterns are stored at every in-range index, including the top one, and then read back. This separates correct word indexing from aliasing between locations.

Other sequences each test one specific behaviour:
- A cycle that presents a store with the toggle left unflipped shows whether the memory reacts to the toggle change or to the write-enable level.
- A store followed directly by a load to the same address shows whether a store really finishes within its half cycle.
- Out-of-range stores whose low bits alias an in-range word show whether bad addresses are masked.
- Toggling on every cycle, alternating stores and loads, shows that back-to-back requests are each serviced in their own cycle.

// File: rtl/tgl_ram_pkg.sv
package tgl_ram_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2
    } op_e;
endpackage

// File: rtl/tgl_ram_sync.sv
// Falling-edge request detector: compares the requester's toggle with a local copy.
module tgl_ram_sync
    import tgl_ram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_tgl_i,
    input  logic wr_en_i,
    output op_e  op_o,
    output logic copy_o
);
    typedef struct packed {
        logic copy;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     fire;

    always_comb begin
        st_d = st_q;
        fire = req_tgl_i ^ st_q.copy;
        op_o = OP_NONE;
        if (fire) begin
            st_d.copy = req_tgl_i;
            op_o      = wr_en_i ? OP_STORE : OP_LOAD;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign copy_o = st_q.copy;

    // R2: once a request is seen, the copy follows the toggle at the next falling edge
    a_r2_copy_follows: assert property (@(negedge clk) disable iff (!rst_n)
        (op_o != OP_NONE) |=> (copy_o == $past(req_tgl_i)));

    // R2: with no request the copy holds
    a_r2_copy_holds: assert property (@(negedge clk) disable iff (!rst_n)
        (op_o == OP_NONE) |=> $stable(copy_o));
endmodule

// File: rtl/tgl_ram_array.sv
// Falling-edge word array with read-data register and load-done flag.
module tgl_ram_array
    import tgl_ram_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DEPTH  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ld_done_o
);
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W + 1)'(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic              done;
    } arr_st_t;

    arr_st_t           st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              in_range;
    logic [DATA_W-1:0] rd_word;
    logic              wr_go;

    always_comb begin
        in_range = ({1'b0, addr_i} < DEPTH_L);
        rd_word  = in_range ? mem_q[addr_i] : '0;
        wr_go    = (op_i == OP_STORE) && in_range;
        st_d      = st_q;
        st_d.done = (op_i == OP_LOAD);
        if (op_i == OP_LOAD) st_d.rd = rd_word;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(negedge clk) begin
        if (wr_go) mem_q[addr_i] <= wr_data_i;
    end

    assign rd_data_o = st_q.rd;
    assign ld_done_o = st_q.done;

    // R8: a load beyond the depth yields zero
    a_r8_oob_zero: assert property (@(negedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD && !in_range) |=> (rd_data_o == '0));

    // R11: stores and idle cycles do not disturb the read-data register
    a_r11_rd_stable: assert property (@(negedge clk) disable iff (!rst_n)
        (op_i != OP_LOAD) |=> $stable(rd_data_o));

    // R3: a load raises the done flag for the following rising edge
    a_r3_load_flag: assert property (@(negedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD) |=> ld_done_o);
endmodule

// File: rtl/tgl_ram_dest.sv
// Rising-edge destination register fed by the read-data register.
module tgl_ram_dest #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_done_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] dest_o
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
    } dst_st_t;

    dst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_done_i) st_d.val = rd_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dest_o = st_q.val;

    // R4: capture after a load
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done_i |=> (dest_o == $past(rd_data_i)));

    // R4: hold otherwise
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_done_i |=> $stable(dest_o));
endmodule

// File: rtl/tgl_ram_port.sv
module tgl_ram_port
    import tgl_ram_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DEPTH  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] dest_o
);
    op_e  op;
    logic copy;
    logic ld_done;

    tgl_ram_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_tgl_i (req_tgl_i),
        .wr_en_i   (wr_en_i),
        .op_o      (op),
        .copy_o    (copy)
    );

    tgl_ram_array #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .ld_done_o (ld_done)
    );

    tgl_ram_dest #(
        .DATA_W (DATA_W)
    ) u_dest (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_done_i (ld_done),
        .rd_data_i (rd_data_o),
        .dest_o    (dest_o)
    );

    // R1: out of reset the toggle and copy agree while the toggle stays low
    a_r1_quiet: assert property (@(negedge clk) disable iff (!rst_n)
        (!req_tgl_i && !copy) |-> (op == OP_NONE));

    initial begin
        a_r6_depth_fits: assert (DEPTH <= (1 << ADDR_W));
    end
endmodule

// File: tb/tgl_ram_port_test.sv
module tgl_ram_port_test;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 48;

    typedef struct {
        int                cyc;
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] dst;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_tgl = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data, dest;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    exp_t q[$];
    logic [DATA_W-1:0] ref_mem [DEPTH];
    logic [DATA_W-1:0] exp_rd = '0, exp_dst = '0;

    tgl_ram_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
        .clk (clk), .rst_n (rst_n), .req_tgl_i (req_tgl), .addr_i (addr),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_data_o (rd_data), .dest_o (dest)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one call per data-path cycle; go=0 leaves the toggle alone
    task automatic access(bit go, bit wr, int a, logic [DATA_W-1:0] d, string tag);
        exp_t e;
        @(posedge clk);
        #1;
        addr    = ADDR_W'(a);
        wr_en   = wr;
        wr_data = d;
        if (go) begin
            req_tgl = ~req_tgl;
            if (wr) begin
                if (a < DEPTH) ref_mem[a] = d;
            end else begin
                exp_rd  = (a < DEPTH) ? ref_mem[a] : '0;
                exp_dst = exp_rd;
            end
        end
        e.cyc = cyc; e.rd = exp_rd; e.dst = exp_dst; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0 && q[0].cyc == cyc - 1) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " rd_data"}, rd_data, e.rd);
                check({e.tag, " dest"}, dest, e.dst);
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, '0);
        check("R1 reset dest", dest, '0);
        rst_n = 1'b1;
        // R1: toggle held at 0 with load inputs: nothing changes
        access(0, 0, 3, '0, "R1 idle after reset");
        // R5/R6: distinct patterns at every index
        for (int i = 0; i < DEPTH; i++)
            access(1, 1, i, 32'hA5000000 ^ (i * 32'h01010101) ^ (i << 20), "R5 store");
        for (int i = 0; i < DEPTH; i++)
            access(1, 0, i, '0, "R3 R6 load");
        // R2: unflipped toggle with store inputs must not write
        access(1, 1, 5, 32'h12345678, "R5 store 5");
        access(0, 1, 5, 32'hDEADBEEF, "R2 no toggle");
        access(0, 1, 5, 32'hDEADBEEF, "R2 no toggle");
        access(1, 0, 5, '0, "R2 load 5");
        // R9: store then immediate load
        access(1, 1, 9, 32'h0BADF00D, "R9 store");
        access(1, 0, 9, '0, "R9 load after store");
        access(1, 1, 47, 32'hFFFF0000, "R6 top store");
        access(1, 0, 47, '0, "R6 top load");
        // R7/R8: out of range aliasing low bits of index 15
        access(1, 1, 15, 32'h5555AAAA, "R7 store 15");
        access(1, 1, 63, 32'h11111111, "R7 oob store");
        access(1, 1, 48, 32'h22222222, "R7 oob store");
        access(1, 0, 15, '0, "R7 load 15");
        access(1, 0, 0, '0, "R7 load 0");
        access(1, 0, 63, '0, "R8 oob load");
        access(1, 0, 15, '0, "R4 reload 15");
        access(1, 0, 50, '0, "R8 oob load");
        // R10/R11: back-to-back alternating
        for (int i = 0; i < 16; i++) begin
            access(1, 1, 20 + i, 32'hC0DE0000 + i, "R10 R11 b2b store");
            access(1, 0, 20 + i, '0, "R10 b2b load");
        end
        access(0, 0, 0, '0, "R4 idle hold");
        access(0, 0, 0, '0, "R4 idle hold");
        repeat (3) @(posedge clk);
        #3;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard left %0d items", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule